// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds the single atomic reservation of one processor core and decides whether a store-conditional may commit. A load-linked event with a word-aligned address opens a reservation. The reservation stays open until one of these happens: a write by another agent lands in the same address granule, the local pipeline reports an exception, a taken branch or another memory access, or too many instructions retire. A store-conditional request gets a pass or fail verdict one clock later. The store may be written to memory only when the verdict is pass. Every store-conditional closes the reservation, whether it passed or failed.

The size of the compare granule is a parameter. It runs from one 32-bit word up to a 4 KB page. A coarser granule needs a smaller comparator, but it raises the number of false failures. The block also flags load-linked or store-conditional addresses that are not word-aligned. Every interface is a set of single-cycle event pulses, and the block accepts one of each per cycle. It never stalls and has no ready signal. The verdict pulse cannot be held off, so the pipeline must capture it in the cycle it appears.

Top module: `resv_monitor`

## Requirements
- R1: A load-linked pulse with `ll_addr[1:0]==0` makes `resv_valid` 1 after the next clock edge, records that address and restarts the instruction counter. A second load-linked replaces the earlier address.
- R2: A store-conditional pulse gives `sc_done` high for exactly the following cycle. `sc_pass` is 1 in that cycle only if four conditions hold: the reservation was valid, `sc_addr[1:0]==0`, `sc_addr` falls in the reserved granule, and no drop event arrived in the same cycle.
- R3: An exception, a taken branch or another local memory access drops the reservation. A store-conditional in the same cycle as any of these fails.
- R4: After any store-conditional, passed or failed, `resv_valid` is 0 and later store-conditionals fail until a new load-linked.
- R5: A load-linked or store-conditional whose low two address bits are not 00 pulses `addr_err` in the following cycle. Such a store-conditional fails, and such a load-linked leaves no reservation.
- R6: A snooped write whose address shares the reserved granule drops the reservation, whatever data it carries. A snooped write outside the granule has no effect. A matching snoop in the same cycle as a store-conditional makes it fail.
- R7: The reservation survives `MAX_INSNS` retire pulses after the load-linked and is dropped by the next one.
- R8: `GRAN_LG2` (2 to 12) sets the granule size. A store-conditional to another word of the same granule passes, and a snoop anywhere in the granule drops the reservation.
- R9: During and right after reset, `resv_valid`, `sc_done`, `sc_pass` and `addr_err` are 0.
- R10: When a load-linked and a store-conditional arrive in the same cycle, the store-conditional is judged against the earlier reservation, and the new reservation stays open afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_valid | input | 1 | Load-linked event |
| ll_addr | input | AW | Load-linked byte address |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | AW | Store-conditional byte address |
| snoop_valid | input | 1 | Write by another agent observed |
| snoop_addr | input | AW | Address of the observed write |
| exc_taken | input | 1 | Local exception taken |
| branch_taken | input | 1 | Local taken branch |
| mem_access | input | 1 | Other local load or store |
| retire | input | 1 | One instruction retired |
| resv_valid | output | 1 | Reservation open |
| sc_done | output | 1 | Verdict strobe, one cycle after request |
| sc_pass | output | 1 | Store-conditional may commit |
| addr_err | output | 1 | Misaligned load-linked or store-conditional |

## Verification
The bench targets collisions within one cycle. These are a matching snoop or an exception together with a store-conditional, and a load-linked together with a store-conditional. A design with the wrong priority in either case would let a broken reservation commit, or would throw away a freshly opened one. The bench also places the timeout exactly at the limit, where an off-by-one counter would drop the reservation one instruction early or late. It checks that a new load-linked restarts the count, since a counter that is never cleared drops long-lived reservations. Finally, a word-granule instance and a page-granule instance run side by side on the same addresses, which exposes a granule mask that is too wide or too narrow.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef struct packed {
    logic snoop;
    logic exc;
    logic branch;
    logic mem;
    logic timeout;
  } drop_t;

  function automatic logic word_aligned(input logic [1:0] low_bits);
    return low_bits == 2'b00;
  endfunction

endpackage

// File: rtl/resv_granule_cmp.sv
module resv_granule_cmp #(
  parameter int AW       = 32,
  parameter int GRAN_LG2 = 2
) (
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic          same
);
  // Offset bits inside the granule take no part in the compare.
  logic unused_lo;
  assign unused_lo = ^{addr_a[GRAN_LG2-1:0], addr_b[GRAN_LG2-1:0]};

  assign same = addr_a[AW-1:GRAN_LG2] == addr_b[AW-1:GRAN_LG2];
endmodule

// File: rtl/resv_age_counter.sv
module resv_age_counter #(
  parameter int MAX_INSNS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic retire,
  output logic expire
);
  localparam int CW = $clog2(MAX_INSNS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_INSNS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (restart)               cnt_q <= '0;
    else if (retire && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = !restart && retire && (cnt_q == LIMIT);

  // R7: the count saturates at the limit
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  // R7: restart clears the age
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int AW        = 32,
  parameter int GRAN_LG2  = 2,
  parameter int MAX_INSNS = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ll_valid,
  input  logic [AW-1:0] ll_addr,
  input  logic          sc_valid,
  input  logic [AW-1:0] sc_addr,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  input  logic          exc_taken,
  input  logic          branch_taken,
  input  logic          mem_access,
  input  logic          retire,
  output logic          resv_valid,
  output logic          sc_done,
  output logic          sc_pass,
  output logic          addr_err
);
  initial assert (GRAN_LG2 >= 2 && GRAN_LG2 <= 12);

  logic [AW-1:0] resv_addr_q;
  logic          resv_q;
  logic          done_q, pass_q, err_q;

  logic  ll_ok, ll_bad, sc_aligned;
  logic  snoop_same, sc_same, aged_out;
  logic  any_drop, pass_d, resv_d;
  drop_t drop;

  assign ll_ok      = ll_valid && word_aligned(ll_addr[1:0]);
  assign ll_bad     = ll_valid && !word_aligned(ll_addr[1:0]);
  assign sc_aligned = word_aligned(sc_addr[1:0]);

  resv_granule_cmp #(.AW(AW), .GRAN_LG2(GRAN_LG2)) u_snoop_cmp (
    .addr_a(snoop_addr), .addr_b(resv_addr_q), .same(snoop_same));

  resv_granule_cmp #(.AW(AW), .GRAN_LG2(GRAN_LG2)) u_sc_cmp (
    .addr_a(sc_addr), .addr_b(resv_addr_q), .same(sc_same));

  resv_age_counter #(.MAX_INSNS(MAX_INSNS)) u_age (
    .clk(clk), .rst_n(rst_n), .restart(ll_ok), .retire(retire),
    .expire(aged_out));

  always_comb begin
    drop.snoop   = snoop_valid && snoop_same;
    drop.exc     = exc_taken;
    drop.branch  = branch_taken;
    drop.mem     = mem_access;
    drop.timeout = aged_out;
    any_drop     = |drop;
  end

  // Verdict uses the reservation as it stood before this cycle.
  assign pass_d = sc_valid && resv_q && sc_aligned && sc_same && !any_drop;

  always_comb begin
    if (ll_ok)                             resv_d = 1'b1;
    else if (ll_bad || sc_valid || any_drop) resv_d = 1'b0;
    else                                   resv_d = resv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q      <= 1'b0;
      resv_addr_q <= '0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      resv_q <= resv_d;
      if (ll_ok) resv_addr_q <= ll_addr;
      done_q <= sc_valid;
      pass_q <= pass_d;
      err_q  <= ll_bad || (sc_valid && !sc_aligned);
    end
  end

  assign resv_valid = resv_q;
  assign sc_done    = done_q;
  assign sc_pass    = pass_q;
  assign addr_err   = err_q;

  // R1: an aligned load-linked opens the reservation
  a_r1_ll_opens: assert property (@(posedge clk) disable iff (!rst_n)
    ll_ok |=> resv_valid);
  // R2: a pass needs an open reservation beforehand
  a_r2_pass_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !resv_valid) |=> !sc_pass);
  // R2: pass only appears with the verdict strobe
  a_r2_pass_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> sc_done);
  // R3: local drop events close the reservation
  a_r3_local_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((exc_taken || branch_taken || mem_access) && !ll_valid) |=> !resv_valid);
  // R4: every store-conditional closes the reservation
  a_r4_sc_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !ll_valid) |=> !resv_valid);
  // R5: misaligned store-conditional fails with an error
  a_r5_misaligned_sc: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && sc_addr[1:0] != 2'b00) |=> (addr_err && !sc_pass));
  // R6: a same-cycle snoop hit beats the store-conditional
  a_r6_snoop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && drop.snoop) |=> !sc_pass);
endmodule

// File: tb/resv_monitor_test.sv
`timescale 1ns/1ps
module resv_monitor_test;
  localparam int AW = 32;
  localparam int MAXI = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ll_valid = 0, sc_valid = 0, snoop_valid = 0;
  logic [AW-1:0] ll_addr = '0, sc_addr = '0, snoop_addr = '0;
  logic exc_taken = 0, branch_taken = 0, mem_access = 0, retire = 0;
  logic rv_w, done_w, pass_w, err_w;
  logic rv_p, done_p, pass_p, err_p;

  int n_tests = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  resv_monitor #(.AW(AW), .GRAN_LG2(2), .MAX_INSNS(MAXI)) uut (
    .clk, .rst_n, .ll_valid, .ll_addr, .sc_valid, .sc_addr, .snoop_valid,
    .snoop_addr, .exc_taken, .branch_taken, .mem_access, .retire,
    .resv_valid(rv_w), .sc_done(done_w), .sc_pass(pass_w), .addr_err(err_w));

  resv_monitor #(.AW(AW), .GRAN_LG2(12), .MAX_INSNS(MAXI)) uut_pg (
    .clk, .rst_n, .ll_valid, .ll_addr, .sc_valid, .sc_addr, .snoop_valid,
    .snoop_addr, .exc_taken, .branch_taken, .mem_access, .retire,
    .resv_valid(rv_p), .sc_done(done_p), .sc_pass(pass_p), .addr_err(err_p));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Inputs set after a falling edge; one rising edge; inputs cleared.
  task automatic step();
    @(negedge clk);
    ll_valid = 0; sc_valid = 0; snoop_valid = 0;
    exc_taken = 0; branch_taken = 0; mem_access = 0; retire = 0;
  endtask

  task automatic do_ll(input logic [AW-1:0] a);
    ll_valid = 1; ll_addr = a; step();
  endtask

  task automatic do_sc(input logic [AW-1:0] a);
    sc_valid = 1; sc_addr = a; step();
  endtask

  task automatic t_reset();
    check("R9", "resv_valid", rv_w, 0);
    check("R9", "sc_done", done_w, 0);
    check("R9", "sc_pass", pass_w, 0);
    check("R9", "addr_err", err_w, 0);
  endtask

  task automatic t_basic();
    do_ll(32'h100);
    check("R1", "resv after ll", rv_w, 1);
    do_sc(32'h100);
    check("R2", "sc_done", done_w, 1);
    check("R2", "sc_pass", pass_w, 1);
    check("R4", "resv after sc", rv_w, 0);
    step();
    check("R2", "sc_done one cycle", done_w, 0);
    do_sc(32'h100);
    check("R4", "second sc pass", pass_w, 0);
    check("R4", "second sc done", done_w, 1);
  endtask

  task automatic t_local_drops();
    for (int k = 0; k < 3; k++) begin
      do_ll(32'h140);
      if (k == 0) exc_taken = 1;
      else if (k == 1) branch_taken = 1;
      else mem_access = 1;
      step();
      check("R3", $sformatf("resv after drop %0d", k), rv_w, 0);
      do_sc(32'h140);
      check("R3", $sformatf("sc after drop %0d", k), pass_w, 0);
    end
    do_ll(32'h140);
    exc_taken = 1; sc_valid = 1; sc_addr = 32'h140; step();
    check("R3", "sc with same-cycle exc", pass_w, 0);
  endtask

  task automatic t_snoop();
    do_ll(32'h200);
    snoop_valid = 1; snoop_addr = 32'h300; step();
    check("R6", "resv after far snoop", rv_w, 1);
    snoop_valid = 1; snoop_addr = 32'h200; step();
    check("R6", "resv after near snoop", rv_w, 0);
    do_ll(32'h200);
    snoop_valid = 1; snoop_addr = 32'h200;
    sc_valid = 1; sc_addr = 32'h200; step();
    check("R6", "sc with same-cycle snoop", pass_w, 0);
  endtask

  task automatic t_misalign();
    do_ll(32'h102);
    check("R5", "err after bad ll", err_w, 1);
    check("R5", "resv after bad ll", rv_w, 0);
    do_ll(32'h100);
    check("R5", "err after good ll", err_w, 0);
    do_sc(32'h101);
    check("R5", "err after bad sc", err_w, 1);
    check("R5", "bad sc pass", pass_w, 0);
  endtask

  task automatic t_timeout();
    do_ll(32'h180);
    for (int i = 0; i < MAXI; i++) begin
      retire = 1; step();
    end
    check("R7", "resv at limit", rv_w, 1);
    retire = 1; step();
    check("R7", "resv past limit", rv_w, 0);
    do_ll(32'h180);
    for (int i = 0; i < 300; i++) begin retire = 1; step(); end
    do_ll(32'h180);
    for (int i = 0; i < 300; i++) begin retire = 1; step(); end
    check("R1", "counter restarted by ll", rv_w, 1);
    do_sc(32'h180);
    check("R7", "sc within limit", pass_w, 1);
  endtask

  task automatic t_granule();
    do_ll(32'h1000);
    do_sc(32'h1004);
    check("R8", "word granule other word", pass_w, 0);
    check("R8", "page granule other word", pass_p, 1);
    do_ll(32'h1000);
    snoop_valid = 1; snoop_addr = 32'h1FF0; step();
    check("R8", "word granule snoop in page", rv_w, 1);
    check("R8", "page granule snoop in page", rv_p, 0);
  endtask

  task automatic t_replace();
    do_ll(32'h100);
    do_ll(32'h200);
    do_sc(32'h100);
    check("R1", "sc to replaced address", pass_w, 0);
  endtask

  task automatic t_same_cycle();
    do_ll(32'h100);
    ll_valid = 1; ll_addr = 32'h200; sc_valid = 1; sc_addr = 32'h100; step();
    check("R10", "sc judged on old resv", pass_w, 1);
    check("R10", "new resv kept", rv_w, 1);
    do_sc(32'h200);
    check("R10", "sc on new resv", pass_w, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_local_drops();
    t_snoop();
    t_misalign();
    t_timeout();
    t_granule();
    t_replace();
    t_same_cycle();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule